// File: doc/BRIEF.md
# Interrupt Pin Request and Remote-IRR Tracker

This block sits between the raw interrupt lines of a 24-pin interrupt router and its delivery stage. It corrects each line for the pin's configured polarity and keeps a request bit per pin. It decides which pins need a service and hands one service at a time to the delivery stage. For level-triggered pins it keeps the remote-IRR handshake, which blocks a pin from being serviced again until software signals end-of-interrupt with that pin's vector. Polarity, trigger kind, mask and vector for every pin come from a redirection table held outside the block. They arrive as flat configuration vectors.

Each pin lane registers its effective level. A rise of the effective level marks the pin as pending. For a level pin, this happens only when its remote-IRR is clear. An end-of-interrupt strobe can also mark a level pin as pending. A fixed-priority picker selects the lowest pending pin. A two-state sequencer then either offers that pin to the delivery stage or discards it because it is masked.

The sequencer states are:
- `ST_IDLE`: the sequencer scans for pending pins. When a pending pin is present and unmasked, the **grant** transition moves to `ST_OFFER`. When the lowest pending pin is masked, the **drop** action discards it and the sequencer stays in `ST_IDLE`.
- `ST_OFFER`: the sequencer holds the service request. The **done** transition on an acknowledgement returns to `ST_IDLE`.

Top module: `pinreq_tracker`

## Requirements
- R1: After reset, `svc_valid` is low and every bit of `req_bits` and `rirr_bits` is 0.
- R2: The effective level of pin i is `pin_raw[i]` XOR `cfg_pol[i]`. For a level pin (`cfg_level[i]`=1), `req_bits[i]` follows the effective level one clock later.
- R3: For an edge pin (`cfg_level[i]`=0), a 0-to-1 change of the effective level sets its request and schedules exactly one service. Holding the level high schedules nothing more. Granting the service clears `req_bits[i]`.
- R4: For a level pin, a 0-to-1 change of the effective level schedules a service only while `rirr_bits[i]` is 0. While `rirr_bits[i]` is 1, level changes schedule nothing.
- R5: When the lowest pending pin has `cfg_mask[i]`=1, its pending service is discarded without raising `svc_valid`. An edge pin's request is also cleared.
- R6: On an accepted service (`svc_valid` and `dlv_ack` both high), the behaviour depends on `dlv_hit` and the trigger kind:
  - For a level pin with `dlv_hit`=1, `rirr_bits[pin]` is set.
  - For a level pin with `dlv_hit`=0, `rirr_bits[pin]` is left clear.
  - An edge pin never sets its remote-IRR bit.
- R7: A one-cycle `eoi_valid` with vector V acts on every level pin whose `cfg_vec` slice (bits `i*8 +: 8`) equals V. It clears `rirr_bits` of those pins. Each such pin that is unmasked and still has its request set is serviced again. Edge pins ignore end-of-interrupt.
- R8: Only one service is outstanding at a time. Pending pins are served lowest index first. `svc_valid` stays high, with `svc_pin` and `svc_vec` stable, until `dlv_ack`.
- R9: While `svc_valid` is high, `svc_pin` holds the served pin's index (below 24) and `svc_vec` holds that pin's vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_raw | input | 24 | Raw interrupt line levels |
| cfg_pol | input | 24 | Per-pin polarity, 1 inverts the line |
| cfg_level | input | 24 | Per-pin trigger kind, 1 = level, 0 = edge |
| cfg_mask | input | 24 | Per-pin mask, 1 = masked |
| cfg_vec | input | 192 | Per-pin vector, pin i in bits i*8 +: 8 |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vec | input | 8 | Vector carried by the end-of-interrupt |
| svc_valid | output | 1 | Service request to the delivery stage |
| svc_pin | output | 5 | Index of the pin being served |
| svc_vec | output | 8 | Vector of the pin being served |
| dlv_ack | input | 1 | Delivery stage accepts the current service |
| dlv_hit | input | 1 | The accepted service reached at least one target |
| req_bits | output | 24 | Request register per pin |
| rirr_bits | output | 24 | Remote-IRR bit per pin |

## Verification
Some internal faults show up one or two clocks after the stimulus as a wrong service at the ports: a lost or stuck pending bit, a wrong priority order, or a misread polarity. The pin is missed, served twice, or served out of order. A remote-IRR bit that is set or cleared wrongly becomes visible on `rirr_bits` one clock after the acknowledgement or the end-of-interrupt. It also shows later as a missing or extra re-service once the next end-of-interrupt arrives. An edge request that is not cleared at grant appears on `req_bits` one clock after the grant.

// File: rtl/pinreq_pkg.sv
package pinreq_pkg;

    localparam int DEF_PINS = 24;
    localparam int DEF_VW   = 8;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_OFFER = 1'b1
    } svc_state_e;

endpackage

// File: rtl/pinreq_lane.sv
module pinreq_lane #(
    parameter int VW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raw,
    input  logic          pol,
    input  logic          lvl,
    input  logic          mask,
    input  logic [VW-1:0] vec,
    input  logic          eoi_valid,
    input  logic [VW-1:0] eoi_vec,
    input  logic          grant,
    input  logic          drop,
    input  logic          done,
    input  logic          hit,
    output logic          req,
    output logic          pend,
    output logic          rirr
);

    logic eff;
    logic eff_q;
    logic rise;
    logic eoi_hit;
    logic ack_set;
    logic taken;

    assign eff     = raw ^ pol;
    assign rise    = eff & ~eff_q;
    assign eoi_hit = eoi_valid && (vec == eoi_vec) && lvl;
    assign ack_set = done && hit && lvl;
    assign taken   = grant || drop;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eff_q <= 1'b0;
            req   <= 1'b0;
            pend  <= 1'b0;
            rirr  <= 1'b0;
        end else begin
            eff_q <= eff;

            // request register
            if (lvl) begin
                req <= eff;
            end else if (rise) begin
                req <= 1'b1;
            end else if (taken) begin
                req <= 1'b0;
            end

            // pending service
            if (rise && (!lvl || !rirr)) begin
                pend <= 1'b1;
            end else if (eoi_hit && !ack_set && !mask && req) begin
                pend <= 1'b1;
            end else if (taken) begin
                pend <= 1'b0;
            end

            // remote-IRR: an acknowledgement outranks a same-cycle EOI
            if (ack_set) begin
                rirr <= 1'b1;
            end else if (eoi_hit) begin
                rirr <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pinreq_pick.sv
module pinreq_pick #(
    parameter int N  = 24,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  pend,
    output logic          any,
    output logic [IW-1:0] idx
);

    always_comb begin
        any = |pend;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/pinreq_fsm.sv
module pinreq_fsm
    import pinreq_pkg::*;
#(
    parameter int IW = 5,
    parameter int VW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          any_pend,
    input  logic [IW-1:0] pick_idx,
    input  logic          pick_masked,
    input  logic [VW-1:0] pick_vec,
    input  logic          dlv_ack,
    output logic          svc_valid,
    output logic [IW-1:0] svc_pin,
    output logic [VW-1:0] svc_vec,
    output logic          grant_en,
    output logic          drop_en,
    output logic          done_en
);

    svc_state_e state;
    svc_state_e state_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            svc_pin <= '0;
            svc_vec <= '0;
        end else begin
            state <= state_nxt;
            if (grant_en) begin
                svc_pin <= pick_idx;
                svc_vec <= pick_vec;
            end
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (any_pend && !pick_masked) begin
                    state_nxt = ST_OFFER;
                end
            end
            ST_OFFER: begin
                if (dlv_ack) begin
                    state_nxt = ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        svc_valid = (state == ST_OFFER);
        grant_en  = (state == ST_IDLE) && any_pend && !pick_masked;
        drop_en   = (state == ST_IDLE) && any_pend && pick_masked;
        done_en   = (state == ST_OFFER) && dlv_ack;
    end

endmodule

// File: rtl/pinreq_tracker.sv
module pinreq_tracker #(
    parameter int NPINS = 24,
    parameter int VW    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NPINS-1:0]    pin_raw,
    input  logic [NPINS-1:0]    cfg_pol,
    input  logic [NPINS-1:0]    cfg_level,
    input  logic [NPINS-1:0]    cfg_mask,
    input  logic [NPINS*VW-1:0] cfg_vec,
    input  logic                eoi_valid,
    input  logic [VW-1:0]       eoi_vec,
    output logic                svc_valid,
    output logic [$clog2(NPINS)-1:0] svc_pin,
    output logic [VW-1:0]       svc_vec,
    input  logic                dlv_ack,
    input  logic                dlv_hit,
    output logic [NPINS-1:0]    req_bits,
    output logic [NPINS-1:0]    rirr_bits
);

    localparam int IW = $clog2(NPINS);

    logic [NPINS-1:0] pend_bits;
    logic             any_pend;
    logic [IW-1:0]    pick_idx;
    logic             pick_masked;
    logic [VW-1:0]    pick_vec;
    logic             grant_en;
    logic             drop_en;
    logic             done_en;

    pinreq_pick #(.N(NPINS), .IW(IW)) u_pick (
        .pend (pend_bits),
        .any  (any_pend),
        .idx  (pick_idx)
    );

    assign pick_masked = cfg_mask[pick_idx];
    assign pick_vec    = cfg_vec[int'(pick_idx)*VW +: VW];

    pinreq_fsm #(.IW(IW), .VW(VW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .any_pend    (any_pend),
        .pick_idx    (pick_idx),
        .pick_masked (pick_masked),
        .pick_vec    (pick_vec),
        .dlv_ack     (dlv_ack),
        .svc_valid   (svc_valid),
        .svc_pin     (svc_pin),
        .svc_vec     (svc_vec),
        .grant_en    (grant_en),
        .drop_en     (drop_en),
        .done_en     (done_en)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_lane
        logic sel_pick;
        logic sel_svc;
        assign sel_pick = (pick_idx == IW'(g));
        assign sel_svc  = (svc_pin == IW'(g));

        pinreq_lane #(.VW(VW)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .raw       (pin_raw[g]),
            .pol       (cfg_pol[g]),
            .lvl       (cfg_level[g]),
            .mask      (cfg_mask[g]),
            .vec       (cfg_vec[g*VW +: VW]),
            .eoi_valid (eoi_valid),
            .eoi_vec   (eoi_vec),
            .grant     (grant_en && sel_pick),
            .drop      (drop_en && sel_pick),
            .done      (done_en && sel_svc),
            .hit       (dlv_hit),
            .req       (req_bits[g]),
            .pend      (pend_bits[g]),
            .rirr      (rirr_bits[g])
        );
    end

endmodule

// File: rtl/pinreq_tracker_chk.sv
module pinreq_tracker_chk #(
    parameter int NPINS = 24,
    parameter int VW    = 8,
    parameter int IW    = $clog2(NPINS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] cfg_mask,
    input logic [NPINS-1:0] cfg_level,
    input logic             svc_valid,
    input logic [IW-1:0]    svc_pin,
    input logic [VW-1:0]    svc_vec,
    input logic             dlv_ack,
    input logic             dlv_hit,
    input logic [NPINS-1:0] rirr_bits
);

    localparam logic [IW:0] PIN_LIMIT = (IW + 1)'(NPINS);

    logic armed;
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R8
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (svc_valid && !dlv_ack) |=> (svc_valid && $stable(svc_pin) && $stable(svc_vec)));

    // R6
    rirr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ((rirr_bits & ~$past(rirr_bits)) != '0) |-> $past(svc_valid && dlv_ack && dlv_hit));

    // R6
    rirr_single_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $countones(rirr_bits & ~$past(rirr_bits)) <= 1);

    // R6
    rirr_edge_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ((rirr_bits & ~$past(rirr_bits) & ~$past(cfg_level)) == '0));

    // R5
    no_masked_offer_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $rose(svc_valid) |-> ((($past(cfg_mask) >> svc_pin) & NPINS'(1)) == '0));

    // R9
    pin_range_chk: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        svc_valid |-> ({1'b0, svc_pin} < PIN_LIMIT));

endmodule

bind pinreq_tracker pinreq_tracker_chk #(.NPINS(NPINS), .VW(VW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_mask  (cfg_mask),
    .cfg_level (cfg_level),
    .svc_valid (svc_valid),
    .svc_pin   (svc_pin),
    .svc_vec   (svc_vec),
    .dlv_ack   (dlv_ack),
    .dlv_hit   (dlv_hit),
    .rirr_bits (rirr_bits)
);

// File: tb/pinreq_tracker_test.sv
module pinreq_tracker_test;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 24;
    localparam int VW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     pin_raw = '0;
    logic [NP-1:0]     cfg_pol = '0;
    logic [NP-1:0]     cfg_level = '0;
    logic [NP-1:0]     cfg_mask = '0;
    logic [NP*VW-1:0]  cfg_vec = '0;
    logic              eoi_valid = 1'b0;
    logic [VW-1:0]     eoi_vec = '0;
    logic              svc_valid;
    logic [4:0]        svc_pin;
    logic [VW-1:0]     svc_vec;
    logic              dlv_ack = 1'b0;
    logic              dlv_hit = 1'b0;
    logic [NP-1:0]     req_bits;
    logic [NP-1:0]     rirr_bits;

    logic              hit_cfg = 1'b1;
    int                n_cmp = 0;
    int                n_bad = 0;

    typedef struct packed { logic [4:0] pin; logic [VW-1:0] vec; } exp_t;
    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pinreq_tracker #(.NPINS(NP), .VW(VW)) uut (
        .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .cfg_pol(cfg_pol),
        .cfg_level(cfg_level), .cfg_mask(cfg_mask), .cfg_vec(cfg_vec),
        .eoi_valid(eoi_valid), .eoi_vec(eoi_vec), .svc_valid(svc_valid),
        .svc_pin(svc_pin), .svc_vec(svc_vec), .dlv_ack(dlv_ack),
        .dlv_hit(dlv_hit), .req_bits(req_bits), .rirr_bits(rirr_bits)
    );

    function automatic logic [VW-1:0] vec_of(int p);
        return cfg_vec[p*VW +: VW];
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic expect_svc(input int p);
        exp_t e;
        e.pin = 5'(p);
        e.vec = vec_of(p);
        exp_q.push_back(e);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain(input string tag);
        settle(12);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
        exp_q.delete();
    endtask

    task automatic send_eoi(input logic [VW-1:0] v);
        @(negedge clk);
        eoi_valid = 1'b1;
        eoi_vec   = v;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    // monitor: compares every service against the scoreboard and acknowledges it
    initial begin
        forever begin
            @(negedge clk);
            dlv_ack = 1'b0;
            if (rst_n && svc_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected service pin", int'(svc_pin), -1);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(svc_pin == e.pin, "R8 service order pin", int'(svc_pin), int'(e.pin));
                    check(svc_vec == e.vec, "R9 service vector", int'(svc_vec), int'(e.vec));
                end
                dlv_ack = 1'b1;
                dlv_hit = hit_cfg;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NP; i++) cfg_vec[i*VW +: VW] = 8'h80 + 8'(i);
        cfg_vec[3*VW +: VW]  = 8'h33;
        cfg_vec[5*VW +: VW]  = 8'h35;
        cfg_vec[7*VW +: VW]  = 8'h47;
        cfg_vec[9*VW +: VW]  = 8'h49;
        cfg_vec[16*VW +: VW] = 8'h60;
        cfg_vec[17*VW +: VW] = 8'h60;
        cfg_vec[20*VW +: VW] = 8'h70;
        cfg_level = '0;
        cfg_level[7] = 1'b1; cfg_level[9] = 1'b1; cfg_level[12] = 1'b1;
        cfg_level[13] = 1'b1; cfg_level[16] = 1'b1; cfg_level[17] = 1'b1;
        cfg_mask[11] = 1'b1; cfg_mask[12] = 1'b1; cfg_mask[13] = 1'b1;
        cfg_pol[5] = 1'b1; cfg_pol[13] = 1'b1;
        pin_raw[5] = 1'b1; pin_raw[13] = 1'b1;

        settle(4);
        rst_n = 1'b1;
        settle(3);

        // R1 reset state
        check(svc_valid == 1'b0, "R1 svc_valid", int'(svc_valid), 0);
        check(req_bits == '0, "R1 req_bits", int'(req_bits), 0);
        check(rirr_bits == '0, "R1 rirr_bits", int'(rirr_bits), 0);

        // R3 edge pin: one service per rise, request cleared
        expect_svc(3);
        pin_raw[3] = 1'b1;
        drain("R3 missing edge service");
        check(req_bits[3] == 1'b0, "R3 edge request cleared", int'(req_bits[3]), 0);
        settle(10);
        pin_raw[3] = 1'b0; settle(2);
        expect_svc(3);
        pin_raw[3] = 1'b1;
        drain("R3 second rise");

        // R2 polarity on edge pin 5 (raw high = inactive)
        expect_svc(5);
        pin_raw[5] = 1'b0;
        drain("R2 inverted edge pin");

        // R2 polarity on level pin 13 (masked): request follows inverted level
        check(req_bits[13] == 1'b0, "R2 level inverted idle", int'(req_bits[13]), 0);
        pin_raw[13] = 1'b0;
        settle(3);
        check(req_bits[13] == 1'b1, "R2 level inverted active", int'(req_bits[13]), 1);

        // R4 R6 level pin with hit sets remote-IRR
        expect_svc(7);
        pin_raw[7] = 1'b1;
        drain("R4 level service");
        check(rirr_bits[7] == 1'b1, "R6 remote-IRR set on hit", int'(rirr_bits[7]), 1);
        pin_raw[7] = 1'b0; settle(2);
        pin_raw[7] = 1'b1;
        drain("R4 blocked while remote-IRR set");

        // R7 EOI with request still set re-services
        expect_svc(7);
        send_eoi(8'h47);
        drain("R7 re-service after EOI");
        check(rirr_bits[7] == 1'b1, "R7 remote-IRR set again", int'(rirr_bits[7]), 1);
        pin_raw[7] = 1'b0;
        settle(3);
        check(req_bits[7] == 1'b0, "R2 level request follows low", int'(req_bits[7]), 0);
        send_eoi(8'h47);
        drain("R7 EOI with request low");
        check(rirr_bits[7] == 1'b0, "R7 remote-IRR cleared", int'(rirr_bits[7]), 0);

        // R6 level pin without hit keeps remote-IRR clear
        hit_cfg = 1'b0;
        expect_svc(9);
        pin_raw[9] = 1'b1;
        drain("R6 no-hit service");
        check(rirr_bits[9] == 1'b0, "R6 remote-IRR clear on miss", int'(rirr_bits[9]), 0);
        hit_cfg = 1'b1;
        pin_raw[9] = 1'b0;

        // R5 masked edge and level pins
        pin_raw[11] = 1'b1;
        pin_raw[12] = 1'b1;
        drain("R5 masked pins");
        check(req_bits[11] == 1'b0, "R5 masked edge request dropped", int'(req_bits[11]), 0);
        check(req_bits[12] == 1'b1, "R5 masked level request held", int'(req_bits[12]), 1);
        check(rirr_bits[12] == 1'b0, "R5 masked level remote-IRR", int'(rirr_bits[12]), 0);

        // R8 priority: pins 14 and 2 rise together
        expect_svc(2);
        expect_svc(14);
        pin_raw[14] = 1'b1;
        pin_raw[2]  = 1'b1;
        drain("R8 priority pair");

        // R7 shared vector on two level pins
        expect_svc(16);
        expect_svc(17);
        pin_raw[16] = 1'b1;
        pin_raw[17] = 1'b1;
        drain("R7 shared vector first round");
        check(rirr_bits[17:16] == 2'b11, "R6 both remote-IRR set", int'(rirr_bits[17:16]), 3);
        expect_svc(16);
        expect_svc(17);
        send_eoi(8'h60);
        drain("R7 shared vector re-service");
        pin_raw[16] = 1'b0;
        pin_raw[17] = 1'b0;
        settle(2);
        send_eoi(8'h60);
        drain("R7 shared vector clear");
        check(rirr_bits[17:16] == 2'b00, "R7 both remote-IRR cleared", int'(rirr_bits[17:16]), 0);

        // R7 edge pin ignores EOI
        expect_svc(20);
        pin_raw[20] = 1'b1;
        drain("R3 edge pin 20");
        send_eoi(8'h70);
        drain("R7 EOI on edge pin");
        check(req_bits[20] == 1'b0, "R7 edge request untouched", int'(req_bits[20]), 0);
        check(rirr_bits[20] == 1'b0, "R7 edge remote-IRR", int'(rirr_bits[20]), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule